// File: doc/BRIEF.md
# Charger Configuration Register Target on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C) and sits in front of a battery charge controller. It holds the settings that the controller uses: the cell chemistry, the choice between the two regulation voltages, a charge current code and a threshold select for the end of charge. It also lets a host read two live status flags that the controller drives. A host writes a register by sending the target address, a register index byte and one or more data bytes. It reads a register by writing the index, sending a repeated START, sending the address again with the read bit set and then clocking out data bytes.

The bus lines are sampled with a fast system clock, and the target pulls SDA low through an open-drain enable. Along with the raw register fields, the block presents the charge current and the end-of-charge current in milliamps, decoded from the programmed codes. While the supply-valid input is low, every register returns to its default value and stays there, as happens when the battery voltage falls too low to retain settings.

Top module: `chg_cfg_i2c_target`

## Requirements
- R1: The target acknowledges only the 7-bit address 0x45, where the eighth bit is 0 for write and 1 for read. For any other address it leaves SDA released in the acknowledge slot and ignores the rest of the transfer until the next START.
- R2: A write transfer is address+W, a register index byte, then data bytes. The target acknowledges each byte and stores every data byte into the indexed register. The index does not advance, so the last byte wins.
- R3: A read transfer is address+W and an index byte, then a repeated START, address+R and data bytes sent MSB first. Each byte the host acknowledges is followed by the same register again. A host NACK ends the read.
- R4: Register 0x00 holds bit 7 = chemistry (0 Li-Ion, 1 Ni-MH), bit 6 = regulation voltage (0 for 4.1 V, 1 for 4.2 V) and bits 3..0 = charge current code. Bits 5..4 read as 0.
- R5: Register 0x01 reads bit 3 = end-of-charge status input, bit 2 = charging status input (both live, read-only) and bits 1..0 = end-of-charge select. Bits 7..4 read as 0. Writes to bits 7..2 have no effect.
- R6: After reset, register 0x00 is 0x00 and the end-of-charge select is 01.
- R7: While supply_ok is low, all register fields are held at their defaults. Writes have no effect during that time.
- R8: The charge current output equals 500 + 50·code mA for codes 0..9. Codes 10..15 give 950 mA.
- R9: The end-of-charge current output is C/10 for select 0 or 1, floor(3C/20) for select 2 and C/5 for select 3, where C is the decoded charge current.
- R10: A register index above 0x01 is acknowledged, reads as 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Low forces every register to its default |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | When high, the pad pulls SDA low |
| stat_done | input | 1 | End-of-charge status from the controller |
| stat_charging | input | 1 | Charging status from the controller |
| cfg_nimh | output | 1 | Chemistry select, 1 = Ni-MH |
| cfg_vreg_hi | output | 1 | Regulation voltage select, 1 = 4.2 V |
| cfg_ichg_code | output | 4 | Raw charge current code |
| cfg_ichg_ma | output | 10 | Decoded charge current in mA |
| cfg_eoc_sel | output | 2 | Raw end-of-charge select |
| cfg_eoc_ma | output | 10 | Decoded end-of-charge current in mA |

## Verification
Random register writes, mixing valid and out-of-range current codes and all four select values, are each read back under random status inputs. This separates the stored fields from the live ones and shows that the unused bits stay zero. Directed transfers cover the rest. A foreign address checks that no acknowledge is given and that the registers stay unchanged. A multi-byte write and a multi-byte read check that the index does not advance. An out-of-map index checks the zero read and the dropped write. A supply drop, together with a write attempted while the supply is low, shows the reload of the defaults.

// File: rtl/chg_cfg_pkg.sv
package chg_cfg_pkg;

    localparam int unsigned ICHG_BASE_MA = 500;
    localparam int unsigned ICHG_STEP_MA = 50;
    localparam logic [3:0]  ICHG_CODE_MAX = 4'd9;
    localparam logic [7:0]  IDX_MAIN = 8'h00;
    localparam logic [7:0]  IDX_AUX  = 8'h01;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_ACK_DEV,
        ST_IDX,
        ST_ACK_IDX,
        ST_WR,
        ST_ACK_WR,
        ST_RD,
        ST_RD_ACK
    } tgt_state_e;

    typedef struct packed {
        logic       nimh;
        logic       vreg_hi;
        logic [3:0] ichg_code;
        logic [1:0] eoc_sel;
    } chg_cfg_t;

    localparam chg_cfg_t CFG_DEFAULT = '{nimh: 1'b0, vreg_hi: 1'b0,
                                         ichg_code: 4'd0, eoc_sel: 2'b01};

    function automatic logic [9:0] ichg_ma_f(input logic [3:0] code);
        logic [3:0] c;
        c = (code > ICHG_CODE_MAX) ? ICHG_CODE_MAX : code;
        return 10'(ICHG_BASE_MA + ICHG_STEP_MA * int'(c));
    endfunction

    function automatic logic [9:0] eoc_ma_f(input logic [9:0] ma, input logic [1:0] sel);
        logic [11:0] prod;
        logic [2:0]  twentieths;
        case (sel)
            2'd2:    twentieths = 3'd3;
            2'd3:    twentieths = 3'd4;
            default: twentieths = 3'd2;
        endcase
        prod = 12'(ma) * 12'(twentieths);
        return 10'(prod / 12'd20);
    endfunction

endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl,
    output logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_in;
                    sda_pipe <= sda_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_pipe[STAGES-1];
            sda_q <= sda_pipe[STAGES-1];
        end
    end

    assign scl       = scl_pipe[STAGES-1];
    assign sda       = sda_pipe[STAGES-1];
    assign scl_rise  = scl & ~scl_q;
    assign scl_fall  = ~scl & scl_q;
    assign start_det = scl & scl_q & sda_q & ~sda;
    assign stop_det  = scl & scl_q & ~sda_q & sda;

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import chg_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h45,
    parameter int unsigned BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sda,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_det,
    input  logic                 stop_det,
    input  logic [BYTE_BITS-1:0] rd_byte,
    output logic                 sda_low,
    output logic [BYTE_BITS-1:0] idx,
    output logic                 wr_en,
    output logic [BYTE_BITS-1:0] wr_byte
);
    localparam int unsigned CW = $clog2(BYTE_BITS + 1);
    localparam logic [CW-1:0] FULL = CW'(BYTE_BITS);
    localparam logic [CW-1:0] LAST = CW'(BYTE_BITS - 1);

    tgt_state_e           state;
    logic [CW-1:0]        bit_cnt;
    logic [BYTE_BITS-1:0] shreg;
    logic [BYTE_BITS-1:0] tx;
    logic                 rw;
    logic                 host_ack;

    always_ff @(posedge clk) begin
        wr_en <= 1'b0;
        if (rst) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            tx       <= '0;
            rw       <= 1'b0;
            idx      <= '0;
            sda_low  <= 1'b0;
            host_ack <= 1'b0;
            wr_byte  <= '0;
        end else if (start_det) begin
            state   <= ST_DEV;
            bit_cnt <= '0;
            sda_low <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            sda_low <= 1'b0;
        end else begin
            case (state)
                ST_DEV, ST_IDX, ST_WR: begin
                    if (scl_rise && bit_cnt != FULL) begin
                        shreg   <= {shreg[BYTE_BITS-2:0], sda};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == FULL) begin
                        bit_cnt <= '0;
                        if (state == ST_DEV) begin
                            if (shreg[BYTE_BITS-1:1] == DEV_ADDR) begin
                                rw      <= shreg[0];
                                sda_low <= 1'b1;
                                state   <= ST_ACK_DEV;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_IDX) begin
                            idx     <= shreg;
                            sda_low <= 1'b1;
                            state   <= ST_ACK_IDX;
                        end else begin
                            wr_en   <= 1'b1;
                            wr_byte <= shreg;
                            sda_low <= 1'b1;
                            state   <= ST_ACK_WR;
                        end
                    end
                end
                ST_ACK_DEV: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rw) begin
                            tx      <= rd_byte;
                            sda_low <= ~rd_byte[BYTE_BITS-1];
                            state   <= ST_RD;
                        end else begin
                            sda_low <= 1'b0;
                            state   <= ST_IDX;
                        end
                    end
                end
                ST_ACK_IDX, ST_ACK_WR: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        sda_low <= 1'b0;
                        state   <= ST_WR;
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (bit_cnt == LAST) begin
                            sda_low  <= 1'b0;
                            host_ack <= 1'b0;
                            state    <= ST_RD_ACK;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            tx      <= {tx[BYTE_BITS-2:0], 1'b0};
                            sda_low <= ~tx[BYTE_BITS-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda;
                    end else if (scl_fall) begin
                        bit_cnt <= '0;
                        if (host_ack) begin
                            tx      <= rd_byte;
                            sda_low <= ~rd_byte[BYTE_BITS-1];
                            state   <= ST_RD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    sda_low <= 1'b0;
                end
            endcase
        end
    end

    // R1: a foreign address never earns an acknowledge
    assert_no_ack_foreign_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DEV && scl_fall && bit_cnt == FULL && !start_det && !stop_det &&
         shreg[BYTE_BITS-1:1] != DEV_ADDR) |=> !sda_low);

    // R3: SDA is only pulled in acknowledge or read-data phases
    assert_drive_phase_R3: assert property (@(posedge clk) disable iff (rst)
        sda_low |-> (state inside {ST_ACK_DEV, ST_ACK_IDX, ST_ACK_WR, ST_RD}));

    // R2: a stored byte is always acknowledged
    assert_write_acked_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (state == ST_ACK_WR && sda_low));

endmodule

// File: rtl/chg_cfg_regs.sv
module chg_cfg_regs
    import chg_cfg_pkg::*;
#(
    parameter int unsigned BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 supply_ok,
    input  logic                 wr_en,
    input  logic [BYTE_BITS-1:0] wr_byte,
    input  logic [BYTE_BITS-1:0] idx,
    input  logic                 stat_done,
    input  logic                 stat_charging,
    output logic [BYTE_BITS-1:0] rd_byte,
    output chg_cfg_t             cfg
);
    chg_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst || !supply_ok) begin
            cfg_q <= CFG_DEFAULT;
        end else if (wr_en) begin
            if (idx == IDX_MAIN) begin
                cfg_q.nimh      <= wr_byte[7];
                cfg_q.vreg_hi   <= wr_byte[6];
                cfg_q.ichg_code <= wr_byte[3:0];
            end else if (idx == IDX_AUX) begin
                cfg_q.eoc_sel <= wr_byte[1:0];
            end
        end
    end

    always_comb begin
        rd_byte = '0;
        if (idx == IDX_MAIN) begin
            rd_byte[7]   = cfg_q.nimh;
            rd_byte[6]   = cfg_q.vreg_hi;
            rd_byte[3:0] = cfg_q.ichg_code;
        end else if (idx == IDX_AUX) begin
            rd_byte[3]   = stat_done;
            rd_byte[2]   = stat_charging;
            rd_byte[1:0] = cfg_q.eoc_sel;
        end
    end

    assign cfg = cfg_q;

    // R7: a low supply leaves only default contents
    assert_supply_reload_R7: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (cfg_q == CFG_DEFAULT));

    // R10: writes to an unmapped index change nothing
    assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx > IDX_AUX && supply_ok) |=> $stable(cfg_q));

    // R5: writing the second register never touches the first one's fields
    assert_aux_write_scope_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == IDX_AUX && supply_ok) |=>
        (cfg_q.nimh == $past(cfg_q.nimh) && cfg_q.vreg_hi == $past(cfg_q.vreg_hi) &&
         cfg_q.ichg_code == $past(cfg_q.ichg_code)));

endmodule

// File: rtl/chg_cfg_i2c_target.sv
module chg_cfg_i2c_target
    import chg_cfg_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h45,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_drive_low,
    input  logic       stat_done,
    input  logic       stat_charging,
    output logic       cfg_nimh,
    output logic       cfg_vreg_hi,
    output logic [3:0] cfg_ichg_code,
    output logic [9:0] cfg_ichg_ma,
    output logic [1:0] cfg_eoc_sel,
    output logic [9:0] cfg_eoc_ma
);
    localparam int unsigned BYTE_BITS = 8;

    logic                 scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_BITS-1:0] rd_byte, idx, wr_byte;
    logic                 wr_en;
    chg_cfg_t             cfg;

    i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl       (scl_s),
        .sda       (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_engine #(.DEV_ADDR(DEV_ADDR), .BYTE_BITS(BYTE_BITS)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .sda       (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_byte   (rd_byte),
        .sda_low   (sda_drive_low),
        .idx       (idx),
        .wr_en     (wr_en),
        .wr_byte   (wr_byte)
    );

    chg_cfg_regs #(.BYTE_BITS(BYTE_BITS)) u_regs (
        .clk           (clk),
        .rst           (rst),
        .supply_ok     (supply_ok),
        .wr_en         (wr_en),
        .wr_byte       (wr_byte),
        .idx           (idx),
        .stat_done     (stat_done),
        .stat_charging (stat_charging),
        .rd_byte       (rd_byte),
        .cfg           (cfg)
    );

    assign cfg_nimh      = cfg.nimh;
    assign cfg_vreg_hi   = cfg.vreg_hi;
    assign cfg_ichg_code = cfg.ichg_code;
    assign cfg_eoc_sel   = cfg.eoc_sel;
    assign cfg_ichg_ma   = ichg_ma_f(cfg.ichg_code);
    assign cfg_eoc_ma    = eoc_ma_f(cfg_ichg_ma, cfg.eoc_sel);

    // R8: out-of-range codes saturate at the top current
    assert_ichg_clamp_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_ichg_code > 4'd9) |-> (cfg_ichg_ma == 10'd950));

    // R9: the end-of-charge current never exceeds a fifth of the charge current
    assert_eoc_bound_R9: assert property (@(posedge clk) disable iff (rst)
        (12'(cfg_eoc_ma) * 12'd5) <= 12'(cfg_ichg_ma));

endmodule

// File: tb/chg_cfg_i2c_target_tb.sv
module chg_cfg_i2c_target_tb;

    localparam int Q = 8;
    localparam logic [6:0] ADDR = 7'h45;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic stat_done = 1'b0;
    logic stat_charging = 1'b0;
    logic sda_drive_low;
    logic cfg_nimh, cfg_vreg_hi;
    logic [3:0] cfg_ichg_code;
    logic [9:0] cfg_ichg_ma, cfg_eoc_ma;
    logic [1:0] cfg_eoc_sel;
    wire  sda_bus = m_sda & ~sda_drive_low;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // bench-side register model
    logic m_nimh = 1'b0, m_vhi = 1'b0;
    logic [3:0] m_code = 4'd0;
    logic [1:0] m_sel = 2'b01;

    always #2 clk = ~clk;

    chg_cfg_i2c_target u_dut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok),
        .scl_in(m_scl), .sda_in(sda_bus), .sda_drive_low(sda_drive_low),
        .stat_done(stat_done), .stat_charging(stat_charging),
        .cfg_nimh(cfg_nimh), .cfg_vreg_hi(cfg_vreg_hi),
        .cfg_ichg_code(cfg_ichg_code), .cfg_ichg_ma(cfg_ichg_ma),
        .cfg_eoc_sel(cfg_eoc_sel), .cfg_eoc_ma(cfg_eoc_ma)
    );

    function automatic int exp_ichg(input logic [3:0] code);
        int c = (code > 9) ? 9 : int'(code);
        return 500 + 50 * c;
    endfunction

    function automatic int exp_eoc(input int ma, input logic [1:0] sel);
        if (sel == 2) return (ma * 3) / 20;
        if (sel == 3) return ma / 5;
        return ma / 10;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] idx);
        if (idx == 8'h00) return {m_nimh, m_vhi, 2'b00, m_code};
        if (idx == 8'h01) return {4'b0000, stat_done, stat_charging, m_sel};
        return 8'h00;
    endfunction

    task automatic model_write(input logic [7:0] idx, input logic [7:0] d);
        if (idx == 8'h00) begin
            m_nimh = d[7]; m_vhi = d[6]; m_code = d[3:0];
        end else if (idx == 8'h01) begin
            m_sel = d[1:0];
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq();
            m_scl = 1'b1; wq(2);
            m_scl = 1'b0; wq();
        end
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        acked = ~sda_bus;
        wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            m_scl = 1'b1; wq();
            b[i] = sda_bus;
            wq();
            m_scl = 1'b0; wq();
        end
        m_sda = ~give_ack; wq();
        m_scl = 1'b1; wq(2);
        m_scl = 1'b0; wq();
        m_sda = 1'b1;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] d, input string req);
        logic a;
        bus_start();
        send_byte({ADDR, 1'b0}, a); chk({req, " addr ack"}, a, 1);
        send_byte(idx, a);          chk({req, " index ack"}, a, 1);
        send_byte(d, a);            chk({req, " data ack"}, a, 1);
        bus_stop();
        if (supply_ok) model_write(idx, d);
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [7:0] d, input string req);
        logic a;
        bus_start();
        send_byte({ADDR, 1'b0}, a); chk({req, " addr ack"}, a, 1);
        send_byte(idx, a);          chk({req, " index ack"}, a, 1);
        bus_start();
        send_byte({ADDR, 1'b1}, a); chk({req, " read addr ack"}, a, 1);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic check_outputs(input string req);
        chk({req, " R4 mode"}, cfg_nimh, m_nimh);
        chk({req, " R4 vreg"}, cfg_vreg_hi, m_vhi);
        chk({req, " R8 ichg mA"}, cfg_ichg_ma, exp_ichg(m_code));
        chk({req, " R9 eoc mA"}, cfg_eoc_ma, exp_eoc(exp_ichg(m_code), m_sel));
    endtask

    initial begin
        logic [7:0] d, d2;
        logic a;
        void'($urandom(32'd2024));
        repeat (10) @(negedge clk);
        rst = 1'b0;
        wq(2);

        // R6: defaults after reset
        chk("R6 reset code", cfg_ichg_code, 0);
        chk("R6 reset sel", cfg_eoc_sel, 1);
        chk("R6 reset sda", sda_drive_low, 0);
        check_outputs("R6 reset");
        stat_done = 1'b1; stat_charging = 1'b0;
        reg_read(8'h01, d, "R3");
        chk("R6 R5 reg1 read", d, 8'h09);
        reg_read(8'h00, d, "R3");
        chk("R6 R4 reg0 read", d, 8'h00);

        // R1: foreign address gets no ack, transfer ignored
        bus_start();
        send_byte({7'h44, 1'b0}, a); chk("R1 foreign addr nack", a, 0);
        send_byte(8'h00, a);          chk("R1 foreign idx nack", a, 0);
        send_byte(8'hFF, a);          chk("R1 foreign data nack", a, 0);
        bus_stop();
        reg_read(8'h00, d, "R1");
        chk("R1 reg0 unchanged", d, exp_read(8'h00));

        // R4: unused bits 5..4 read zero
        reg_write(8'h00, 8'hFF, "R2");
        reg_read(8'h00, d, "R4");
        chk("R4 reg0 masked", d, 8'hCF);
        check_outputs("R4 R8 clamp");

        // R5: read-only/unused bits of reg1 ignore writes
        stat_done = 1'b0; stat_charging = 1'b1;
        reg_write(8'h01, 8'hFE, "R5");
        reg_read(8'h01, d, "R5");
        chk("R5 reg1 ro bits", d, 8'h06);
        check_outputs("R5 R9 sel2");

        // R10: unmapped index
        reg_write(8'h07, 8'hA5, "R10");
        reg_read(8'h07, d, "R10");
        chk("R10 unmapped read", d, 8'h00);
        reg_read(8'h00, d, "R10");
        chk("R10 reg0 untouched", d, exp_read(8'h00));
        reg_read(8'h01, d, "R10");
        chk("R10 reg1 untouched", d, exp_read(8'h01));

        // R2: multi-byte write, no index advance
        bus_start();
        send_byte({ADDR, 1'b0}, a); chk("R2 burst addr ack", a, 1);
        send_byte(8'h00, a);        chk("R2 burst idx ack", a, 1);
        send_byte(8'h43, a);        chk("R2 burst d0 ack", a, 1);
        send_byte(8'h85, a);        chk("R2 burst d1 ack", a, 1);
        bus_stop();
        model_write(8'h00, 8'h43); model_write(8'h00, 8'h85);
        reg_read(8'h01, d, "R2");
        chk("R2 reg1 not written by burst", d, exp_read(8'h01));
        check_outputs("R2 burst");

        // R3: multi-byte read repeats the same register
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte({ADDR, 1'b1}, a); chk("R3 burst read ack", a, 1);
        recv_byte(1'b1, d);
        recv_byte(1'b0, d2);
        bus_stop();
        chk("R3 burst byte0", d, exp_read(8'h00));
        chk("R3 burst byte1 same reg", d2, exp_read(8'h00));
        wq();
        chk("R3 released after nack", sda_drive_low, 0);

        // R7: supply drop restores defaults and blocks writes
        supply_ok = 1'b0;
        wq();
        m_nimh = 1'b0; m_vhi = 1'b0; m_code = 4'd0; m_sel = 2'b01;
        reg_write(8'h00, 8'hC7, "R7");
        chk("R7 code held default", cfg_ichg_code, 0);
        chk("R7 sel held default", cfg_eoc_sel, 1);
        supply_ok = 1'b1;
        wq();
        check_outputs("R7 after recovery");

        // random mix
        for (int it = 0; it < 30; it++) begin
            logic [7:0] idx, dat;
            idx = 8'($urandom_range(0, 3));
            dat = 8'($urandom);
            reg_write(idx, dat, "R2 rand");
            stat_done = 1'($urandom); stat_charging = 1'($urandom);
            wq();
            reg_read(idx, d, "R3 rand");
            chk("R3 rand readback", d, exp_read(idx));
            check_outputs("R8 R9 rand");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule